// File: doc/BRIEF.md
# Bus Parking and Request Sequencer

This block governs the master side of a bridge on a shared parallel bus. It raises the bridge's bus request when the transaction engine wants the bus. It watches the grant that comes back and issues a one-cycle pulse that tells the frame logic to begin a transaction. When the bus is idle and granted, and the bridge has no request pending, the bus is parked. Parking drives the address/data and command/byte-enable lines to a fixed known pattern, and parity follows one clock later. Only the lower data and command lanes are handled here. The upper lanes and the data phases of a transaction belong to other logic.

A static mode input selects one of two arbitration arrangements. With the on-chip arbiter, the block uses its own request output and grant input. With an off-chip arbiter, the grant-0 output pin carries the bridge's request and the request-0 input pin carries the grant. In that mode, parking depends only on the grant and on bus idleness. Reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `bus_park_seq`

## Requirements
- R1: While reset is applied, and after it, until stimulus says otherwise: `ad_oe`, `cbe_oe`, `par_oe` and `frame_start` are 0, and `req_n_out` and `gnt0_n_out` are 1.
- R2: The effective grant and request pins depend on the mode. With `ext_arb_mode`=0, the grant is `gnt_n_in` low, the request drives `req_n_out` low, and `gnt0_n_out` stays 1. With `ext_arb_mode`=1, the grant is `req0_n_in` low, the request drives `gnt0_n_out` low, and `req_n_out` stays 1.
- R3: The request is asserted one clock after `want_bus` is sampled high and no transaction is active. It is withdrawn at the clock where a transaction starts.
- R4: Parking begins at a clock where the grant is asserted, `bus_idle`=1, no transaction is active and no start is taken. With the on-chip arbiter, the request must also be deasserted. With the off-chip arbiter, the request is not considered.
- R5: At the clock where parking begins, `ad_oe` and `cbe_oe` rise. `par_oe` rises one clock later and falls together with them.
- R6: A clock that samples the grant deasserted while parked turns off all three enables at that clock edge.
- R7: While parked, `want_bus`=1 with the grant still asserted and `bus_idle`=1 starts a transaction at the next clock. No prior request is needed.
- R8: When not parked, a transaction starts at the first clock that samples the grant asserted, `bus_idle`=1, `want_bus`=1 and the request already asserted.
- R9: `frame_start` is high for exactly one cycle. From then until `xfer_done` is sampled high, the block does not park, request or start.
- R10: While parked, `ad_out` equals `PARK_AD` and `cbe_out` equals `PARK_CBE`, both all zeros by default. `par_out` makes the total count of ones over those lines and itself even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_arb_mode | input | 1 | 1 selects the off-chip arbiter pin arrangement |
| want_bus | input | 1 | Transaction engine wants to start a transaction |
| bus_idle | input | 1 | Bus has no transaction in progress |
| xfer_done | input | 1 | Active transaction has finished |
| gnt_n_in | input | 1 | Grant from the on-chip arbiter, active low |
| req0_n_in | input | 1 | Request-0 pin, used as the grant in off-chip mode |
| req_n_out | output | 1 | Own bus request to the on-chip arbiter, active low |
| gnt0_n_out | output | 1 | Grant-0 pin, used as the request in off-chip mode |
| frame_start | output | 1 | One-cycle pulse that begins a transaction |
| ad_oe | output | 1 | Drive enable for address/data lines |
| cbe_oe | output | 1 | Drive enable for command/byte-enable lines |
| par_oe | output | 1 | Drive enable for parity |
| ad_out | output | 32 | Parked address/data value |
| cbe_out | output | 4 | Parked command/byte-enable value |
| par_out | output | 1 | Parity of the parked value |

## Verification
The hardest situation to reach from the ports is a start taken directly from the parked state. The grant has to persist while `want_bus` rises, and the bus must stay idle on the same clock. If the timing is wrong, the request path is taken instead. The stimulus parks the bus first, then raises `want_bus` with the grant held. It repeats this in off-chip mode, where a pending request does not stop parking. A seeded pseudo-random sweep then varies the grant, idleness, mode and completion every cycle, so that grant loss in the middle of parking and parity staggering overlap with starts.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PARK = 2'd1,
    ST_BUSY = 2'd2
  } seq_state_t;
endpackage

// File: rtl/bps_grant_mux.sv
module bps_grant_mux (
  input  logic ext_mode,
  input  logic req_active,
  input  logic gnt_n_in,
  input  logic req0_n_in,
  output logic own_req_n,
  output logic gnt0_n,
  output logic gnt_eff
);
  // Pin remapping between on-chip and off-chip arbitration
  always_comb begin
    if (ext_mode) begin
      gnt_eff   = ~req0_n_in;
      gnt0_n    = ~req_active;
      own_req_n = 1'b1;
    end else begin
      gnt_eff   = ~gnt_n_in;
      gnt0_n    = 1'b1;
      own_req_n = ~req_active;
    end
  end
endmodule

// File: rtl/bps_park_fsm.sv
module bps_park_fsm
  import bps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_mode,
  input  logic       want_bus,
  input  logic       gnt_eff,
  input  logic       bus_idle,
  input  logic       xfer_done,
  output seq_state_t state_q,
  output seq_state_t state_d,
  output logic       req_q,
  output logic       start_q
);
  logic free_bus, start_c, park_c, req_d, start_d;

  always_comb begin
    free_bus = (state_q != ST_BUSY);
    start_c  = free_bus & want_bus & gnt_eff & bus_idle &
               ((state_q == ST_PARK) | req_q);
    park_c   = free_bus & ~start_c & gnt_eff & bus_idle &
               (ext_mode | ~req_q);
    if (state_q == ST_BUSY)
      state_d = xfer_done ? ST_IDLE : ST_BUSY;
    else if (start_c)
      state_d = ST_BUSY;
    else if (park_c)
      state_d = ST_PARK;
    else
      state_d = ST_IDLE;
    req_d   = want_bus & (state_d != ST_BUSY);
    start_d = start_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      start_q <= start_d;
    end
  end

  p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |-> !req_q);
  p_park_needs_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(state_q == ST_PARK)) |-> $past(gnt_eff && bus_idle));
  p_grant_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARK && !gnt_eff) |=> (state_q != ST_PARK));
endmodule

// File: rtl/bps_drive_seq.sv
module bps_drive_seq #(
  parameter int          ADW      = 32,
  parameter int          CBW      = 4,
  parameter logic [31:0] PARK_AD  = 32'h0,
  parameter logic [3:0]  PARK_CBE = 4'h0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           parking,
  input  logic           park_next,
  output logic           ad_oe,
  output logic           cbe_oe,
  output logic           par_oe,
  output logic [ADW-1:0] ad_out,
  output logic [CBW-1:0] cbe_out,
  output logic           par_out
);
  logic par_q, par_d, par_en;

  always_comb begin
    par_d  = park_next & parking;
    par_en = (par_d != par_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      par_q <= 1'b0;
    else if (par_en) par_q <= par_d;
  end

  assign ad_oe   = parking;
  assign cbe_oe  = parking;
  assign par_oe  = par_q;
  assign ad_out  = PARK_AD[ADW-1:0];
  assign cbe_out = PARK_CBE[CBW-1:0];
  assign par_out = ^{ad_out, cbe_out};

  p_par_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ad_oe);
  p_par_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_oe) |-> $past(ad_oe));
endmodule

// File: rtl/bus_park_seq.sv
module bus_park_seq
  import bps_pkg::*;
#(
  parameter int          ADW      = 32,
  parameter int          CBW      = 4,
  parameter logic [31:0] PARK_AD  = 32'h0,
  parameter logic [3:0]  PARK_CBE = 4'h0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ext_arb_mode,
  input  logic           want_bus,
  input  logic           bus_idle,
  input  logic           xfer_done,
  input  logic           gnt_n_in,
  input  logic           req0_n_in,
  output logic           req_n_out,
  output logic           gnt0_n_out,
  output logic           frame_start,
  output logic           ad_oe,
  output logic           cbe_oe,
  output logic           par_oe,
  output logic [ADW-1:0] ad_out,
  output logic [CBW-1:0] cbe_out,
  output logic           par_out
);
  logic       rs_meta, rst_sync_n;
  logic       gnt_eff, req_q;
  seq_state_t state_q, state_d;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta    <= 1'b1;
      rst_sync_n <= rs_meta;
    end
  end

  bps_grant_mux u_mux (
    .ext_mode  (ext_arb_mode),
    .req_active(req_q),
    .gnt_n_in  (gnt_n_in),
    .req0_n_in (req0_n_in),
    .own_req_n (req_n_out),
    .gnt0_n    (gnt0_n_out),
    .gnt_eff   (gnt_eff)
  );

  bps_park_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ext_mode (ext_arb_mode),
    .want_bus (want_bus),
    .gnt_eff  (gnt_eff),
    .bus_idle (bus_idle),
    .xfer_done(xfer_done),
    .state_q  (state_q),
    .state_d  (state_d),
    .req_q    (req_q),
    .start_q  (frame_start)
  );

  bps_drive_seq #(
    .ADW(ADW), .CBW(CBW), .PARK_AD(PARK_AD), .PARK_CBE(PARK_CBE)
  ) u_drv (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .parking  (state_q == ST_PARK),
    .park_next(state_d == ST_PARK),
    .ad_oe    (ad_oe),
    .cbe_oe   (cbe_oe),
    .par_oe   (par_oe),
    .ad_out   (ad_out),
    .cbe_out  (cbe_out),
    .par_out  (par_out)
  );
endmodule

// File: tb/sim_bus_park_seq.sv
module sim_bus_park_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext = 1'b0, want = 1'b0, idle = 1'b1, done = 1'b0;
  logic gnt_n = 1'b1, req0_n = 1'b1;
  logic req_n_o, gnt0_n_o, fstart, ad_oe, cbe_oe, par_oe, par_o;
  logic [31:0] ad_o;
  logic [3:0]  cbe_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bus_park_seq u0 (
    .clk(clk), .rst_n(rst_n), .ext_arb_mode(ext), .want_bus(want),
    .bus_idle(idle), .xfer_done(done), .gnt_n_in(gnt_n), .req0_n_in(req0_n),
    .req_n_out(req_n_o), .gnt0_n_out(gnt0_n_o), .frame_start(fstart),
    .ad_oe(ad_oe), .cbe_oe(cbe_oe), .par_oe(par_oe),
    .ad_out(ad_o), .cbe_out(cbe_o), .par_out(par_o)
  );

  // Behavioural reference: busy flag, parked flag, parity lag, request, start
  bit m_busy, m_park, m_par, m_req, m_start;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_park = 0; m_par = 0; m_req = 0; m_start = 0;
    end else begin
      bit g, go, pk, nb;
      g  = ext ? !req0_n : !gnt_n;
      go = !m_busy && want && g && idle && (m_park || m_req);
      pk = !m_busy && !go && g && idle && (ext || !m_req);
      nb = m_busy ? !done : go;
      m_par   = pk && m_park;
      m_park  = pk;
      m_req   = want && !nb;
      m_start = go;
      m_busy  = nb;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit even_par(input logic [35:0] v);
    int ones = 0;
    for (int i = 0; i < 36; i++) ones += v[i];
    return ones[0];
  endfunction

  task automatic compare_all();
    chk("R4 R5 R6 ad_oe", ad_oe, m_park);
    chk("R5 cbe_oe", cbe_oe, m_park);
    chk("R5 par_oe", par_oe, m_par);
    chk("R7 R8 R9 frame_start", fstart, m_start);
    chk("R2 R3 req_n_out", req_n_o, ext ? 1'b1 : !m_req);
    chk("R2 R3 gnt0_n_out", gnt0_n_o, ext ? !m_req : 1'b1);
    if (m_park) begin
      chk("R10 ad_out", ad_o, 32'h0);
      chk("R10 cbe_out", cbe_o, 4'h0);
      chk("R10 par_out", par_o, even_par({32'h0, 4'h0}));
    end
  endtask

  // Set inputs after a negedge compare, then run one clock
  task automatic step(input bit w, input bit g, input bit i, input bit d);
    @(negedge clk);
    compare_all();
    want = w; idle = i; done = d;
    if (ext) begin req0_n = !g; gnt_n = $urandom_range(0, 1); end
    else     begin gnt_n  = !g; req0_n = 1'b1; end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 ad_oe", ad_oe, 0); chk("R1 par_oe", par_oe, 0);
    chk("R1 frame_start", fstart, 0);
    chk("R1 req_n_out", req_n_o, 1); chk("R1 gnt0_n_out", gnt0_n_o, 1);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 1, 0);
    // R4 R5: park, parity one clock later, then R6 grant loss
    repeat (4) step(0, 1, 1, 0);
    @(negedge clk); chk("R5 par_oe stagger", par_oe, 1);
    repeat (2) step(0, 0, 1, 0);
    chk("R6 ad_oe after grant loss", ad_oe, 0);
    // R4: granted but bus busy, no parking
    repeat (3) step(0, 1, 0, 0);
    // R7: park then start straight from park
    repeat (3) step(0, 1, 1, 0);
    step(1, 1, 1, 0);
    step(0, 1, 1, 0);
    chk("R7 start from park", fstart, 1);
    // R9: busy until done
    repeat (3) step(1, 1, 1, 0);
    step(0, 1, 1, 1);
    // R3 R8: request without grant, then grant
    repeat (3) step(1, 0, 1, 0);
    chk("R3 request asserted", req_n_o, 0);
    step(1, 1, 1, 0);
    step(0, 0, 1, 0);
    chk("R8 start after grant", fstart, 1);
    repeat (2) step(0, 0, 1, 1);
    // R2: off-chip arbiter mode, request pending still parks
    ext = 1'b1;
    repeat (3) step(1, 0, 1, 0);
    chk("R2 gnt0 carries request", gnt0_n_o, 0);
    repeat (2) step(1, 1, 0, 0);
    step(1, 1, 1, 0);
    repeat (3) step(0, 1, 1, 1);
    repeat (3) step(1, 1, 1, 0);
    step(0, 1, 1, 1);
    // Pseudo-random sweep across both modes
    lfsr = 32'h1ACE5;
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (k % 250 == 0) ext = lfsr[7];
      step(lfsr[0], lfsr[1] | lfsr[2], lfsr[3] | lfsr[4], lfsr[5]);
    end
    @(negedge clk); compare_all();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule